// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask for a group of lanes that run one instruction stream in lockstep. Every lane sees every instruction, but a lane only commits a result when its bit in the active mask is set. When a conditional branch arrives, each lane supplies a one-bit predicate giving the direction it wants to go. If every currently active lane agrees, the branch is uniform and only the program counter moves. If they disagree, the block saves the current mask and the pending fall-through work on a hardware stack. It then runs the taken side with the lanes that chose it, and at the next reconvergence marker it switches to the fall-through side with the remaining lanes. A second marker pops the entry and restores the mask held before the branch.

The controller is a small state machine whose state is the path of the innermost open branch. ST_CONVERGED means the stack is empty. ST_TAKEN_PATH means the innermost branch is running its taken side. ST_ELSE_PATH means it is running its fall-through side. The transitions are DIVERGE (any state to ST_TAKEN_PATH, with a push), SWITCH (ST_TAKEN_PATH to ST_ELSE_PATH, on a marker) and REJOIN (ST_ELSE_PATH to ST_CONVERGED when the last entry is popped, or to the path recorded in the entry below). Uniform branches, plain instructions, overflowing pushes and markers seen in ST_CONVERGED leave the state unchanged. Outputs are registered, so they show the effect of an instruction one clock after it is presented.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: After reset the active mask is all ones, the next PC equals the RESET_PC parameter (0 by default) and the overflow flag is 0.
- R2: A valid instruction that is neither a branch nor a marker sets the next PC to seq_pc and leaves the mask unchanged.
- R3: A branch for which every active lane has its predicate set (predicates of inactive lanes do not matter) sets the next PC to branch_target, leaves the mask unchanged and pushes nothing.
- R4: A branch for which no active lane has its predicate set sets the next PC to seq_pc, leaves the mask unchanged and pushes nothing.
- R5: A divergent branch pushes one entry, sets the mask to active AND predicate and the next PC to branch_target.
- R6: The first marker after a divergence sets the mask to the saved active AND NOT predicate and the next PC to that branch's seq_pc, without popping.
- R7: The second marker pops the entry, restores the mask held before the branch and sets the next PC to the marker's seq_pc.
- R8: Nested divergent branches unwind in last-in first-out order, each restoring its own saved mask.
- R9: The stack holds 8 entries. A divergent branch with the stack full sets a sticky overflow flag, leaves the mask and stack unchanged and sets the next PC to seq_pc. Only reset clears the flag.
- R10: A marker with the stack empty is ignored: the mask stays all ones and the next PC is seq_pc.
- R11: While instr_valid is low, the mask, next PC and flag hold their values.
- R12: When is_branch and is_sync are both high, the instruction is treated as a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| is_branch | input | 1 | The instruction is a conditional branch |
| is_sync | input | 1 | The instruction is a reconvergence marker |
| lane_pred | input | LANES (32) | Per-lane branch predicate, 1 = taken |
| branch_target | input | PC_W (32) | Destination PC of the taken side |
| seq_pc | input | PC_W (32) | Address of the instruction that follows this one |
| active_mask | output | LANES (32) | Lanes allowed to commit results |
| next_pc | output | PC_W (32) | PC the lanes fetch next |
| stack_overflow | output | 1 | Sticky: a push was attempted while the stack was full |

## Verification
The assertions assume that the surrounding sequencer places exactly two markers after each divergent branch and never presents a marker for a branch that did not push. Under that assumption the active mask can never become empty, and ST_CONVERGED always holds a full mask. The stimulus keeps to this rule: every divergent branch is closed by its own pair of markers, and an overflowing branch is treated as a uniform not-taken branch. A stray marker is sent only in ST_CONVERGED, where it must be ignored.

// File: rtl/simt_pkg.sv
package simt_pkg;

    typedef enum logic [1:0] {
        ST_CONVERGED,
        ST_TAKEN_PATH,
        ST_ELSE_PATH
    } ctl_state_e;

    typedef enum logic {
        PH_TAKEN,
        PH_ELSE
    } path_phase_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEQ,
        OP_UNIFORM_T,
        OP_UNIFORM_N,
        OP_DIVERGE,
        OP_OVERFLOW,
        OP_SWITCH,
        OP_REJOIN
    } step_op_e;

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] else_mask,
    output logic             all_taken,
    output logic             none_taken
);
    always_comb begin
        taken_mask = active & pred;
        else_mask  = active & ~pred;
        all_taken  = (else_mask == '0);
        none_taken = (taken_mask == '0);
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flip,
    input  logic [LANES-1:0] in_saved,
    input  logic [LANES-1:0] in_pend,
    input  logic [PC_W-1:0]  in_pend_pc,
    output logic [LANES-1:0] top_saved,
    output logic [LANES-1:0] top_pend,
    output logic [PC_W-1:0]  top_pend_pc,
    output path_phase_e      under_phase,
    output logic [CNT_W-1:0] depth,
    output logic             full,
    output logic             empty
);
    logic [LANES-1:0] saved_q  [DEPTH];
    logic [LANES-1:0] pend_q   [DEPTH];
    logic [PC_W-1:0]  pendpc_q [DEPTH];
    path_phase_e      phase_q  [DEPTH];

    assign full  = (depth == CNT_W'(DEPTH));
    assign empty = (depth == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            depth <= '0;
        else if (push && !full)
            depth <= depth + 1'b1;
        else if (pop && !empty)
            depth <= depth - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[g]  <= '0;
                pend_q[g]   <= '0;
                pendpc_q[g] <= '0;
                phase_q[g]  <= PH_TAKEN;
            end else if (push && depth == CNT_W'(g)) begin
                saved_q[g]  <= in_saved;
                pend_q[g]   <= in_pend;
                pendpc_q[g] <= in_pend_pc;
                phase_q[g]  <= PH_TAKEN;
            end else if (flip && depth == CNT_W'(g + 1)) begin
                phase_q[g]  <= PH_ELSE;
            end
        end
    end

    always_comb begin
        top_saved   = '1;
        top_pend    = '0;
        top_pend_pc = '0;
        under_phase = PH_TAKEN;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth == CNT_W'(i + 1)) begin
                top_saved   = saved_q[i];
                top_pend    = pend_q[i];
                top_pend_pc = pendpc_q[i];
            end
            if (depth == CNT_W'(i + 2))
                under_phase = phase_q[i];
        end
    end

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));
endmodule

// File: rtl/simt_diverge_ctrl.sv
module simt_diverge_ctrl
    import simt_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int PC_W     = 32,
    parameter int DEPTH    = 8,
    parameter int RESET_PC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             is_branch,
    input  logic             is_sync,
    input  logic [LANES-1:0] lane_pred,
    input  logic [PC_W-1:0]  branch_target,
    input  logic [PC_W-1:0]  seq_pc,
    output logic [LANES-1:0] active_mask,
    output logic [PC_W-1:0]  next_pc,
    output logic             stack_overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ctl_state_e       state_q, state_d;
    step_op_e         op;
    logic [LANES-1:0] taken_mask, else_mask;
    logic             all_taken, none_taken;
    logic [LANES-1:0] top_saved, top_pend;
    logic [PC_W-1:0]  top_pend_pc;
    path_phase_e      under_phase;
    logic [CNT_W-1:0] depth;
    logic             full, empty;
    logic             do_push, do_pop, do_flip;

    simt_branch_eval #(.LANES(LANES)) eval_i (
        .active     (active_mask),
        .pred       (lane_pred),
        .taken_mask (taken_mask),
        .else_mask  (else_mask),
        .all_taken  (all_taken),
        .none_taken (none_taken)
    );

    simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) stack_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (do_push),
        .pop         (do_pop),
        .flip        (do_flip),
        .in_saved    (active_mask),
        .in_pend     (else_mask),
        .in_pend_pc  (seq_pc),
        .top_saved   (top_saved),
        .top_pend    (top_pend),
        .top_pend_pc (top_pend_pc),
        .under_phase (under_phase),
        .depth       (depth),
        .full        (full),
        .empty       (empty)
    );

    // Instruction classification; a branch takes precedence over a marker.
    always_comb begin
        op = OP_NONE;
        if (instr_valid) begin
            if (is_branch) begin
                if (all_taken)       op = OP_UNIFORM_T;
                else if (none_taken) op = OP_UNIFORM_N;
                else if (full)       op = OP_OVERFLOW;
                else                 op = OP_DIVERGE;
            end else if (is_sync) begin
                unique case (state_q)
                    ST_CONVERGED:  op = OP_SEQ;
                    ST_TAKEN_PATH: op = OP_SWITCH;
                    ST_ELSE_PATH:  op = OP_REJOIN;
                    default:       op = OP_SEQ;
                endcase
            end else begin
                op = OP_SEQ;
            end
        end
    end

    assign do_push = (op == OP_DIVERGE);
    assign do_flip = (op == OP_SWITCH);
    assign do_pop  = (op == OP_REJOIN);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_DIVERGE: state_d = ST_TAKEN_PATH;
            OP_SWITCH:  state_d = ST_ELSE_PATH;
            OP_REJOIN: begin
                if (depth == CNT_W'(1))
                    state_d = ST_CONVERGED;
                else if (under_phase == PH_TAKEN)
                    state_d = ST_TAKEN_PATH;
                else
                    state_d = ST_ELSE_PATH;
            end
            default:    state_d = state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CONVERGED;
        else        state_q <= state_d;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mask    <= '1;
            next_pc        <= PC_W'(RESET_PC);
            stack_overflow <= 1'b0;
        end else begin
            unique case (op)
                OP_NONE: ;
                OP_SEQ, OP_UNIFORM_N: next_pc <= seq_pc;
                OP_UNIFORM_T: next_pc <= branch_target;
                OP_DIVERGE: begin
                    active_mask <= taken_mask;
                    next_pc     <= branch_target;
                end
                OP_OVERFLOW: begin
                    stack_overflow <= 1'b1;
                    next_pc        <= seq_pc;
                end
                OP_SWITCH: begin
                    active_mask <= top_pend;
                    next_pc     <= top_pend_pc;
                end
                OP_REJOIN: begin
                    active_mask <= top_saved;
                    next_pc     <= seq_pc;
                end
                default: ;
            endcase
        end
    end

    assert_mask_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);
    assert_diverge_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DIVERGE) |=> ((active_mask & ~$past(active_mask)) == '0));
    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow);
    assert_converged_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERGED) |-> (active_mask == '1 && empty));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(active_mask) && $stable(next_pc)));
    assert_uniform_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UNIFORM_T || op == OP_UNIFORM_N) |=> $stable(active_mask));
endmodule

// File: tb/simt_diverge_ctrl_tb_top.sv
module simt_diverge_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int LANES = 32;
    localparam int PC_W  = 32;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0, is_branch = 1'b0, is_sync = 1'b0;
    logic [LANES-1:0] lane_pred = '0;
    logic [PC_W-1:0]  branch_target = '0, seq_pc = '0;
    logic [LANES-1:0] active_mask;
    logic [PC_W-1:0]  next_pc;
    logic             stack_overflow;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    // Scoreboard queues
    logic [LANES-1:0] q_mask [$];
    logic [PC_W-1:0]  q_pc   [$];
    logic             q_ovf  [$];
    string            q_tag  [$];

    // Reference model state
    logic [LANES-1:0] m_mask = '1;
    logic [PC_W-1:0]  m_pc = '0;
    logic             m_ovf = 1'b0;
    logic [LANES-1:0] s_saved [DEPTH];
    logic [LANES-1:0] s_pend  [DEPTH];
    logic [PC_W-1:0]  s_pc    [DEPTH];
    bit               s_else  [DEPTH];
    int               m_depth = 0;

    always #(CLK_P/2) clk = ~clk;

    simt_diverge_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_branch(is_branch),
        .is_sync(is_sync), .lane_pred(lane_pred), .branch_target(branch_target),
        .seq_pc(seq_pc), .active_mask(active_mask), .next_pc(next_pc),
        .stack_overflow(stack_overflow)
    );

    task automatic step(input bit v, input bit br, input bit sy,
                        input logic [LANES-1:0] pr, input logic [PC_W-1:0] tgt,
                        input logic [PC_W-1:0] sq, input string tag);
        logic [LANES-1:0] tk, el;
        @(negedge clk);
        instr_valid = v; is_branch = br; is_sync = sy;
        lane_pred = pr; branch_target = tgt; seq_pc = sq;
        tk = m_mask & pr;
        el = m_mask & ~pr;
        if (v) begin
            if (br) begin
                if (el == '0) m_pc = tgt;
                else if (tk == '0) m_pc = sq;
                else if (m_depth == DEPTH) begin m_ovf = 1'b1; m_pc = sq; end
                else begin
                    s_saved[m_depth] = m_mask; s_pend[m_depth] = el;
                    s_pc[m_depth] = sq; s_else[m_depth] = 1'b0;
                    m_depth++;
                    m_mask = tk; m_pc = tgt;
                end
            end else if (sy && m_depth > 0) begin
                if (!s_else[m_depth-1]) begin
                    s_else[m_depth-1] = 1'b1;
                    m_mask = s_pend[m_depth-1]; m_pc = s_pc[m_depth-1];
                end else begin
                    m_depth--;
                    m_mask = s_saved[m_depth]; m_pc = sq;
                end
            end else begin
                m_pc = sq;
            end
        end
        q_mask.push_back(m_mask); q_pc.push_back(m_pc);
        q_ovf.push_back(m_ovf);   q_tag.push_back(tag);
    endtask

    // Monitor: compares one expected item per clock, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q_tag.size() > 0) begin
                logic [LANES-1:0] em; logic [PC_W-1:0] ep; logic eo; string t;
                em = q_mask.pop_front(); ep = q_pc.pop_front();
                eo = q_ovf.pop_front();  t = q_tag.pop_front();
                compared++;
                if (active_mask !== em || next_pc !== ep || stack_overflow !== eo) begin
                    mismatched++;
                    $display("FAIL %s: mask=%h pc=%h ovf=%b expected mask=%h pc=%h ovf=%b",
                             t, active_mask, next_pc, stack_overflow, em, ep, eo);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values seen directly
        compared++;
        if (active_mask !== '1 || next_pc !== '0 || stack_overflow !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: mask=%h pc=%h ovf=%b expected mask=%h pc=0 ovf=0",
                     active_mask, next_pc, stack_overflow, {LANES{1'b1}});
        end
        step(0, 0, 0, '0, '0, 32'h10, "R1_idle");
        // R2 plain instructions
        step(1, 0, 0, '0, '0, 32'h04, "R2");
        step(1, 0, 0, 32'h1234, 32'h99, 32'h08, "R2");
        // R3 uniform taken, then stray marker shows nothing was pushed (R10)
        step(1, 1, 0, '1, 32'h100, 32'h0C, "R3");
        step(1, 0, 1, '0, '0, 32'h104, "R10");
        // R4 uniform not taken
        step(1, 1, 0, '0, 32'h200, 32'h108, "R4");
        // R12 branch wins over marker (uniform taken)
        step(1, 1, 1, '1, 32'h300, 32'h10C, "R12");
        // R5, R6, R7 single divergence
        step(1, 1, 0, 32'h0000_FFFF, 32'h400, 32'h304, "R5");
        step(1, 0, 0, '0, '0, 32'h404, "R2_in_taken");
        // R3 uniform inside divergence: inactive predicates differ
        step(1, 1, 0, 32'h0F0F_FFFF, 32'h410, 32'h408, "R3_subset");
        step(1, 0, 1, '0, '0, 32'h414, "R6");
        step(0, 1, 1, 32'h5, 32'h77, 32'h78, "R11");
        step(1, 0, 1, '0, '0, 32'h500, "R7");
        // R8 nesting
        step(1, 1, 0, 32'hAAAA_AAAA, 32'h600, 32'h504, "R8_outer");
        step(1, 1, 0, 32'hFF00_FF00, 32'h700, 32'h604, "R8_inner");
        step(1, 0, 1, '0, '0, 32'h704, "R8_inner_switch");
        step(1, 0, 1, '0, '0, 32'h708, "R8_inner_pop");
        step(1, 0, 1, '0, '0, 32'h70C, "R8_outer_switch");
        step(1, 1, 0, 32'h0000_0055, 32'h800, 32'h710, "R8_nested_in_else");
        step(1, 0, 1, '0, '0, 32'h804, "R8_switch2");
        step(1, 0, 1, '0, '0, 32'h808, "R8_pop2");
        step(1, 0, 1, '0, '0, 32'h80C, "R8_outer_pop");
        // R9 overflow: fill the stack, one more divergence
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 1, 0, m_mask & ~(m_mask & (~m_mask + 1'b1)), 32'h1000 + i, 32'h2000 + i,
                 (i == DEPTH) ? "R9_overflow" : "R9_fill");
        step(0, 0, 0, '0, '0, '0, "R9_R11_hold");
        for (int i = 0; i < 2 * DEPTH; i++)
            step(1, 0, 1, '0, '0, 32'h3000 + i, "R9_unwind");
        step(1, 0, 1, '0, '0, 32'h4000, "R10_after_unwind");
        step(1, 1, 0, 32'h1, 32'h5000, 32'h4004, "R9_sticky");
        step(1, 0, 1, '0, '0, 32'h5004, "R9_sticky");
        step(1, 0, 1, '0, '0, 32'h5008, "R9_sticky");
        step(0, 0, 0, '0, '0, '0, "R11");
        repeat (3) @(posedge clk);
        #(CLK_P/2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule